// File: doc/BRIEF.md
# Packed-Word Palette Loader

This block holds a colour lookup table of 2^IDX_W entries, each a red, green and blue component of COMP_W bits. A bus master fills it through a small register window. One word offset holds the entry index. A second offset is the colour port. Each word written to the colour port carries four component bytes. These bytes are consumed from the most significant lane down and run red, green, blue for each entry. The component stream therefore straddles word boundaries, and three words fill exactly four entries.

Inside the block, a slot pointer tracks which component comes next and an index register tracks which entry. When a word finishes a partly built entry, the components already held are merged with the new bytes and the whole entry is written in one step. The table is split into an even bank and an odd bank. This lets a word that finishes two consecutive entries write both in the same cycle. A separate pixel port reads any entry with one clock of latency and can be used at any time, including while the table is being loaded.

Top module: `palette_word_loader`

## Requirements
- R1: A write at word offset 0 loads the entry index from the low IDX_W bits of the write data. A write at offset 1 is a colour word. Writes at offsets 2 and 3 change no entry and leave the loading sequence where it was.
- R2: Within a colour word, the byte in bits [31:24] is used first and the byte in bits [7:0] last. The components of an entry arrive as red, then green, then blue, and appear on lut_rgb as red in [23:16], green in [15:8] and blue in [7:0].
- R3: After the index is set to n, three colour words fill entries n, n+1, n+2 and n+3 with their twelve bytes and change no other entry.
- R4: Colour words may arrive on consecutive cycles with no stall. After the third word, loading continues at entry n+4, so 3k words fill 4k consecutive entries.
- R5: The entry index wraps from the last entry to entry 0 during loading.
- R6: An index write returns the component pointer to red. An entry whose three components were not all delivered before that index write keeps its previous colour.
- R7: The colour of the entry selected by lut_idx appears on lut_rgb one clock later, and a new index can be presented every cycle.
- R8: A lookup of an entry in the same cycle as a write to that entry returns the previous colour. A lookup in the following cycle returns the new colour.
- R9: While rst is high, lut_rgb is 0. After reset, the index is 0 and the pointer is at red, so colour words written without an index write fill entries from 0 upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe, one word per cycle |
| wr_ofs | input | 2 | Word offset of the write within the window |
| wr_data | input | 4*COMP_W | Write data: an index or four packed component bytes |
| lut_idx | input | IDX_W | Pixel index to look up |
| lut_rgb | output | 3*COMP_W | Colour of the entry looked up in the previous cycle |

## Verification
The bench builds the block with COMP_W = 8 and IDX_W = 4. This gives a 32-bit colour port and a 16-entry table split into two 8-deep banks. Twelve back-to-back words then cover the whole table, and a load that starts at entry 14 wraps past the last entry within three words. The small table keeps full-table readback short. It also puts the even/odd bank split, the pointer wrap and the index wrap within a few dozen cycles.

// File: rtl/pal_pkg.sv
package pal_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // component slot that the next byte of the stream fills
  typedef enum logic [1:0] {
    SLOT_RED = 2'd0,
    SLOT_GRN = 2'd1,
    SLOT_BLU = 2'd2
  } slot_e;

  // word offsets inside the register window
  typedef enum logic [1:0] {
    OFS_INDEX  = 2'd0,
    OFS_COLOUR = 2'd1,
    OFS_SPARE0 = 2'd2,
    OFS_SPARE1 = 2'd3
  } ofs_e;

  localparam int NUM_SLOTS = 3;  // components per entry
  localparam int LANES     = 4;  // component bytes per bus word
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_ofs,
  input  logic [LANES*COMP_W-1:0]     wr_data,
  output logic                        a_vld,
  output logic [IDX_W-1:0]            a_idx,
  output logic [NUM_SLOTS*COMP_W-1:0] a_rgb,
  output logic                        b_vld,
  output logic [IDX_W-1:0]            b_idx,
  output logic [NUM_SLOTS*COMP_W-1:0] b_rgb
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WORD_W = LANES * COMP_W;
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] TWO = IDX_W'(2);

  logic [IDX_W-1:0]  cur_idx, nxt_idx;
  slot_e             slot, nxt_slot;
  logic [COMP_W-1:0] held_r, held_g, nxt_r, nxt_g;
  logic [COMP_W-1:0] ln [LANES];
  logic              is_index, is_colour;

  // lane 0 is the most significant byte, consumed first
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign ln[k] = wr_data[WORD_W-1-k*COMP_W -: COMP_W];
  end

  assign is_index  = wr_en && (wr_ofs == OFS_INDEX);
  assign is_colour = wr_en && (wr_ofs == OFS_COLOUR);

  always_comb begin
    a_vld    = 1'b0;
    b_vld    = 1'b0;
    a_idx    = cur_idx;
    b_idx    = cur_idx + ONE;
    a_rgb    = {ln[0], ln[1], ln[2]};
    b_rgb    = {ln[1], ln[2], ln[3]};
    nxt_idx  = cur_idx;
    nxt_slot = slot;
    nxt_r    = held_r;
    nxt_g    = held_g;
    if (is_index) begin
      nxt_idx  = wr_data[IDX_W-1:0];
      nxt_slot = SLOT_RED;
    end else if (is_colour) begin
      case (slot)
        SLOT_RED: begin
          // R G B of this entry, R of the next one held
          a_vld    = 1'b1;
          a_rgb    = {ln[0], ln[1], ln[2]};
          nxt_r    = ln[3];
          nxt_slot = SLOT_GRN;
          nxt_idx  = cur_idx + ONE;
        end
        SLOT_GRN: begin
          // G B finish this entry, R G of the next one held
          a_vld    = 1'b1;
          a_rgb    = {held_r, ln[0], ln[1]};
          nxt_r    = ln[2];
          nxt_g    = ln[3];
          nxt_slot = SLOT_BLU;
          nxt_idx  = cur_idx + ONE;
        end
        SLOT_BLU: begin
          // B finishes this entry, then a whole next entry
          a_vld    = 1'b1;
          a_rgb    = {held_r, held_g, ln[0]};
          b_vld    = 1'b1;
          b_rgb    = {ln[1], ln[2], ln[3]};
          nxt_slot = SLOT_RED;
          nxt_idx  = cur_idx + TWO;
        end
        default: nxt_slot = SLOT_RED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= '0;
      slot    <= SLOT_RED;
      held_r  <= '0;
      held_g  <= '0;
    end else begin
      cur_idx <= nxt_idx;
      slot    <= nxt_slot;
      held_r  <= nxt_r;
      held_g  <= nxt_g;
    end
  end

  AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    2'(slot) != 2'b11); // R4

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
    is_index |=> (cur_idx == $past(wr_data[IDX_W-1:0])) && (slot == SLOT_RED)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(is_index || is_colour) |=> $stable(cur_idx) && $stable(slot)); // R1

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (is_colour && slot != SLOT_BLU) |=> cur_idx == $past(cur_idx) + ONE); // R4

  AST_STEP_TWO: assert property (@(posedge clk) disable iff (rst)
    (is_colour && slot == SLOT_BLU) |=> (cur_idx == $past(cur_idx) + TWO) && (slot == SLOT_RED)); // R5
endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
  parameter int AW = 7,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first: a same-cycle write is seen one cycle later
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/palette_word_loader.sv
module palette_word_loader
  import pal_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_ofs,
  input  logic [LANES*COMP_W-1:0]     wr_data,
  input  logic [IDX_W-1:0]            lut_idx,
  output logic [NUM_SLOTS*COMP_W-1:0] lut_rgb
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int RGB_W     = NUM_SLOTS * COMP_W;
  localparam int BANK_AW   = IDX_W - 1;
  localparam int NUM_BANKS = 2;

  logic               a_vld, b_vld;
  logic [IDX_W-1:0]   a_idx, b_idx;
  logic [RGB_W-1:0]   a_rgb, b_rgb;
  logic [RGB_W-1:0]   bank_q [NUM_BANKS];
  logic               odd_q;

  pal_seq #(
    .COMP_W (COMP_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_ofs  (wr_ofs),
    .wr_data (wr_data),
    .a_vld   (a_vld),
    .a_idx   (a_idx),
    .a_rgb   (a_rgb),
    .b_vld   (b_vld),
    .b_idx   (b_idx),
    .b_rgb   (b_rgb)
  );

  // even entries in bank 0, odd entries in bank 1
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic PARITY = 1'(g);
    logic               hit_a, hit_b, we;
    logic [BANK_AW-1:0] wa;
    logic [RGB_W-1:0]   wd;

    assign hit_a = a_vld && (a_idx[0] == PARITY);
    assign hit_b = b_vld && (b_idx[0] == PARITY);
    assign we    = hit_a || hit_b;
    assign wa    = hit_a ? a_idx[IDX_W-1:1] : b_idx[IDX_W-1:1];
    assign wd    = hit_a ? a_rgb : b_rgb;

    pal_bank #(
      .AW (BANK_AW),
      .DW (RGB_W)
    ) u_ram (
      .clk   (clk),
      .rst   (rst),
      .we    (we),
      .waddr (wa),
      .wdata (wd),
      .raddr (lut_idx[IDX_W-1:1]),
      .rdata (bank_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) odd_q <= 1'b0;
    else     odd_q <= lut_idx[0];
  end

  assign lut_rgb = odd_q ? bank_q[1] : bank_q[0];

  AST_BANK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (a_vld && b_vld) |-> (a_idx[0] != b_idx[0])); // R3
endmodule

// File: tb/palette_word_loader_test.sv
module palette_word_loader_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int COMP_W  = 8;
  localparam int IDX_W   = 4;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int WORD_W  = 4 * COMP_W;
  localparam int RGB_W   = 3 * COMP_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_ofs = 2'd0;
  logic [WORD_W-1:0] wr_data = '0;
  logic [IDX_W-1:0]  lut_idx = '0;
  logic [RGB_W-1:0]  lut_rgb;

  always #2 clk = ~clk;

  palette_word_loader #(.COMP_W(COMP_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs),
    .wr_data(wr_data), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
  );

  int checks = 0;
  int errors = 0;

  // reference model of the table and the byte stream
  logic [RGB_W-1:0]  ref_tab [ENTRIES];
  int                m_idx = 0;
  int                m_slot = 0;
  logic [COMP_W-1:0] m_part [3];

  logic [RGB_W-1:0] exp_q [$];
  string            tag_q [$];
  logic             look_valid = 1'b0;
  logic             chk_pend = 1'b0;

  task automatic model_word(input logic [WORD_W-1:0] w);
    for (int k = 0; k < 4; k++) begin
      m_part[m_slot] = w[WORD_W-1-k*COMP_W -: COMP_W];
      if (m_slot == 2) begin
        ref_tab[m_idx] = {m_part[0], m_part[1], m_part[2]};
        m_idx  = (m_idx + 1) % ENTRIES;
        m_slot = 0;
      end else begin
        m_slot++;
      end
    end
  endtask

  // one bus cycle: optional write and optional lookup
  task automatic drive(input logic we, input logic [1:0] ofs, input logic [WORD_W-1:0] d,
                       input logic lk, input int li, input logic use_lit,
                       input logic [RGB_W-1:0] lit, input string tag);
    @(posedge clk); #1;
    wr_en      = we;
    wr_ofs     = ofs;
    wr_data    = d;
    look_valid = lk;
    lut_idx    = IDX_W'(li);
    if (lk) begin
      exp_q.push_back(use_lit ? lit : ref_tab[li]);
      tag_q.push_back(tag);
    end
    if (we && ofs == 2'd0) begin
      m_idx  = int'(d[IDX_W-1:0]);
      m_slot = 0;
    end else if (we && ofs == 2'd1) begin
      model_word(d);
    end
  endtask

  task automatic wr_word(input logic [1:0] ofs, input logic [WORD_W-1:0] d);
    drive(1'b1, ofs, d, 1'b0, 0, 1'b0, '0, "");
  endtask

  task automatic look(input int li, input string tag);
    drive(1'b0, 2'd0, '0, 1'b1, li, 1'b0, '0, tag);
  endtask

  task automatic look_lit(input int li, input logic [RGB_W-1:0] e, input string tag);
    drive(1'b0, 2'd0, '0, 1'b1, li, 1'b1, e, tag);
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, '0, 1'b0, 0, 1'b0, '0, "");
  endtask

  task automatic check_val(input logic [RGB_W-1:0] act, input logic [RGB_W-1:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  // monitor: lookup captured at a rising edge, compared at the next falling edge
  always @(posedge clk) chk_pend <= look_valid;

  always @(negedge clk) begin
    if (chk_pend) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R7: result with no lookup pending, actual %h expected none", lut_rgb);
      end else begin
        check_val(lut_rgb, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) ref_tab[i] = '0;

    // R9: output held at zero during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_val(lut_rgb, '0, "R9 reset output");
    @(posedge clk); #1;
    rst = 1'b0;

    // R9, R4: stream from entry 0 with no index write, twelve words back to back
    for (int i = 0; i < 12; i++)
      wr_word(2'd1, 32'h3C5A_7E91 ^ (32'h0107_0B0D * (i + 1)));
    for (int i = 0; i < 4; i++) look(i, "R9");
    for (int i = 4; i < ENTRIES; i++) look(i, "R4");

    // R2, R3: byte order and four-entry fill, literal expectations
    wr_word(2'd0, 32'd4);
    wr_word(2'd1, 32'hAABB_CCDD);
    wr_word(2'd1, 32'h1122_3344);
    wr_word(2'd1, 32'h5566_7788);
    look_lit(4, 24'hAABBCC, "R2");
    look_lit(5, 24'hDD1122, "R2");
    look_lit(6, 24'h334455, "R3");
    look_lit(7, 24'h667788, "R3");
    look(3, "R3");
    look(8, "R3");

    // R7: new index every cycle, alternating banks
    look(15, "R7");
    look(0, "R7");
    look(9, "R7");
    look(9, "R7");

    // R1: spare offsets ignored in the middle of a stream
    wr_word(2'd0, 32'd8);
    wr_word(2'd1, 32'hDEAD_BEEF);
    wr_word(2'd2, 32'h0000_000C);
    wr_word(2'd1, 32'h0BAD_F00D);
    wr_word(2'd3, 32'h0000_0001);
    wr_word(2'd1, 32'hC001_D00D);
    for (int i = 8; i < 13; i++) look(i, "R1");

    // R5: loading wraps from the last entry to entry 0
    wr_word(2'd0, 32'd14);
    wr_word(2'd1, 32'h1020_3040);
    wr_word(2'd1, 32'h5060_7080);
    wr_word(2'd1, 32'h90A0_B0C0);
    look_lit(14, 24'h102030, "R5");
    look_lit(15, 24'h405060, "R5");
    look_lit(0,  24'h708090, "R5");
    look_lit(1,  24'hA0B0C0, "R5");
    look(2, "R5");

    // R6: index write abandons a partial entry
    wr_word(2'd0, 32'd4);
    wr_word(2'd1, 32'h1234_5678);
    wr_word(2'd0, 32'd10);
    wr_word(2'd1, 32'hF1E2_D3C4);
    wr_word(2'd1, 32'hB5A6_9788);
    wr_word(2'd1, 32'h7968_5A4B);
    look_lit(4, 24'h123456, "R6");
    look_lit(5, 24'hDD1122, "R6");
    look_lit(10, 24'hF1E2D3, "R6");
    for (int i = 11; i < 14; i++) look(i, "R6");

    // R8: lookup in the cycle of the write sees the old colour, then the new
    wr_word(2'd0, 32'd0);
    drive(1'b1, 2'd1, 32'h0102_0304, 1'b1, 0, 1'b0, '0, "R8 old");
    look(0, "R8 new");
    wr_word(2'd1, 32'h0506_0708);
    drive(1'b1, 2'd1, 32'h090A_0B0C, 1'b1, 3, 1'b0, '0, "R8 old");
    look(3, "R8 new");
    look(2, "R8 new");

    idle();
    idle();
    idle();
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R7: actual %0d results missing expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule